// File: doc/BRIEF.md
# Saturating Signed-to-Unsigned Lane Shifter

This unit shifts every lane of a 128-bit vector left by an immediate amount. It reads each lane as a signed two's-complement integer and clamps the shifted value into the unsigned range of the lane. One packed 7-bit immediate sets both the lane width and the shift distance. The immediate arrives as a 4-bit upper field and a 3-bit lower field. A full-width bit selects a 64-bit or a 128-bit vector. A scalar bit restricts the operation to a single lane. Nothing is rounded: bits shifted out of the top only cause clamping.

Operations enter on a valid/ready input and leave on a valid/ready output. Each leaving word carries the result vector and an illegal-encoding flag. A sticky saturation flag is set whenever any active lane clamps. Software clears it with a plain clear pin. The output stage is a single register. A new operation is taken when the register is empty or is being drained in the same cycle. A held result stays stable until it is taken.

Top module: `vshl_usat`

## Requirements
- R1: The lane width is 8 shifted left by the index of the highest set bit of the 4-bit upper immediate field: 8, 16, 32 or 64 bits.
- R2: The shift distance is the unsigned value of {upper field, lower field} minus the lane width, so it ranges from 0 to lane width minus 1.
- R3: A lane whose sign bit is set produces 0 and counts as saturated.
- R4: For a non-negative lane, a shifted value of 2^width or more produces all ones and counts as saturated. Otherwise the lane holds the shifted value exactly, truncated and not rounded.
- R5: The saturation flag is set by any accepted legal operation in which an active lane saturates, and it stays set until `sat_clr` is high. When a set and a clear happen in the same cycle, the set wins.
- R6: In vector mode the active width is 64 bits when `in_full`=0 and 128 bits when `in_full`=1. Result bits above the active width are 0.
- R7: In scalar mode exactly lane 0 is computed, at the decoded lane width, and all higher result bits are 0. `in_full` is ignored in scalar mode.
- R8: The encoding is illegal when the upper field is 0, or when vector mode is selected with upper-field bit 3 set and `in_full`=0. The result then has `out_illegal`=1 and `out_vec` unchanged from the previous result, and the saturation flag is not set.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted operation appears on the outputs after the next rising edge. While `out_valid`=1 and `out_ready`=0, `out_vec` and `out_illegal` hold.
- R10: Lanes beyond the active width never set the saturation flag, even when they would saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_vec | input | 128 | Source vector, lane 0 in the low bits |
| in_immh | input | 4 | Upper immediate field (width and shift high bits) |
| in_immb | input | 3 | Lower immediate field (shift low bits) |
| in_full | input | 1 | 1 selects a 128-bit vector, 0 a 64-bit vector |
| in_scalar | input | 1 | 1 selects single-lane mode |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 128 | Result vector |
| out_illegal | output | 1 | Result belongs to an illegal encoding |
| sat_flag | output | 1 | Sticky saturation flag |
| sat_clr | input | 1 | Clears the saturation flag |

## Verification
The hardest cases to reach from the ports involve cycle-level interactions, not lane values. One is a clear pulse that coincides with a saturating operation. Another is an illegal encoding that must leave the previous vector in place. A third is an offer made while the output is stalled. The bench reaches the first two by pulsing `sat_clr` together with selected operations and by issuing illegal encodings directly after a known legal result. It reaches the third by holding `out_ready` low across a second offer. Lanes that lie above the active width are loaded with negative values, so that a leak into the flag or into the result would show at the outputs.

// File: rtl/vshl_usat_pkg.sv
package vshl_usat_pkg;
  localparam int IMMH_W = 4;
  localparam int IMMB_W = 3;
  localparam int VEC_W  = 128;

  // index of highest set bit of the upper immediate field (0 when empty)
  function automatic logic [1:0] top_set(input logic [IMMH_W-1:0] h);
    logic [1:0] idx;
    idx = '0;
    for (int k = 0; k < IMMH_W; k++)
      if (h[k]) idx = 2'(k);
    return idx;
  endfunction
endpackage

// File: rtl/vshl_usat_decode.sv
module vshl_usat_decode
  import vshl_usat_pkg::*;
#(
  parameter int HW    = IMMH_W,
  parameter int BW    = IMMB_W,
  parameter int VW    = VEC_W,
  parameter int SZ_W  = $clog2(HW),
  parameter int SH_W  = HW + BW - 1,
  parameter int ACT_W = $clog2(VW) + 1
) (
  input  logic [HW-1:0]    immh,
  input  logic [BW-1:0]    immb,
  input  logic             full,
  input  logic             scalar,
  output logic [SZ_W-1:0]  sz,
  output logic [SH_W-1:0]  shamt,
  output logic [ACT_W-1:0] act_bits,
  output logic             illegal
);
  localparam int IMM_W = HW + BW;
  localparam int BASE  = 1 << BW;

  logic [IMM_W-1:0] esize;
  logic [IMM_W-1:0] diff;

  always_comb begin
    sz      = SZ_W'(top_set(immh));
    esize   = IMM_W'(BASE) << sz;
    diff    = {immh, immb} - esize;
    shamt   = diff[SH_W-1:0];
    if (scalar)    act_bits = ACT_W'(esize);
    else if (full) act_bits = ACT_W'(VW);
    else           act_bits = ACT_W'(VW / 2);
    illegal = (immh == '0) || (!scalar && immh[HW-1] && !full);
  end
endmodule

// File: rtl/vshl_usat_lane.sv
module vshl_usat_lane #(
  parameter int W    = 8,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    lane_in,
  input  logic [SH_W-1:0] shamt,
  output logic [W-1:0]    lane_out,
  output logic            lane_sat
);
  logic [2*W-1:0] wide;
  logic           neg, ovf;

  always_comb begin
    wide = {{W{1'b0}}, lane_in} << shamt;
    neg  = lane_in[W-1];
    ovf  = |wide[2*W-1:W];
    if (neg)      lane_out = '0;
    else if (ovf) lane_out = '1;
    else          lane_out = wide[W-1:0];
    lane_sat = neg | ovf;
  end

  // R3: a negative lane always clamps to zero and reports saturation
  always_comb begin
    if (lane_in[W-1])
      a_r3_neg_zero: assert (lane_out == '0 && lane_sat);
  end

  // R4: a saturated lane sits at one of the two range limits
  always_comb begin
    if (lane_sat)
      a_r4_sat_extreme: assert (lane_out == '0 || lane_out == '1);
  end
endmodule

// File: rtl/vshl_usat.sv
module vshl_usat
  import vshl_usat_pkg::*;
#(
  parameter int HW    = IMMH_W,
  parameter int BW    = IMMB_W,
  parameter int VW    = VEC_W,
  parameter int NSZ   = HW,
  parameter int BASE  = 1 << BW,
  parameter int SZ_W  = $clog2(HW),
  parameter int SH_W  = HW + BW - 1,
  parameter int ACT_W = $clog2(VW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_vec,
  input  logic [HW-1:0] in_immh,
  input  logic [BW-1:0] in_immb,
  input  logic          in_full,
  input  logic          in_scalar,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_vec,
  output logic          out_illegal,
  output logic          sat_flag,
  input  logic          sat_clr
);
  logic [SZ_W-1:0]  dec_sz;
  logic [SH_W-1:0]  dec_sh;
  logic [ACT_W-1:0] dec_act;
  logic             dec_ill;

  vshl_usat_decode #(
    .HW(HW), .BW(BW), .VW(VW), .SZ_W(SZ_W), .SH_W(SH_W), .ACT_W(ACT_W)
  ) u_dec (
    .immh(in_immh), .immb(in_immb), .full(in_full), .scalar(in_scalar),
    .sz(dec_sz), .shamt(dec_sh), .act_bits(dec_act), .illegal(dec_ill)
  );

  logic [VW-1:0] cand_vec [NSZ];
  logic          cand_sat [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int W = BASE << g;
    localparam int N = VW / W;
    logic [VW-1:0] y_all, y_msk;
    logic [N-1:0]  s_all, on;

    for (genvar i = 0; i < N; i++) begin : g_ln
      localparam logic [ACT_W:0] LANE_END = (ACT_W+1)'((i + 1) * W);
      vshl_usat_lane #(.W(W), .SH_W(SH_W)) u_lane (
        .lane_in (in_vec[i*W +: W]),
        .shamt   (dec_sh),
        .lane_out(y_all[i*W +: W]),
        .lane_sat(s_all[i])
      );
      assign on[i] = LANE_END <= {1'b0, dec_act};
      assign y_msk[i*W +: W] = y_all[i*W +: W] & {W{on[i]}};
    end

    assign cand_vec[g] = y_msk;
    assign cand_sat[g] = |(s_all & on);
  end

  logic [VW-1:0] sel_vec;
  logic          sel_sat;
  logic          accept;

  always_comb begin
    sel_vec = cand_vec[dec_sz];
    sel_sat = cand_sat[dec_sz];
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  logic [ACT_W-1:0] out_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_vec     <= '0;
      out_illegal <= 1'b0;
      out_act     <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_illegal <= dec_ill;
      if (!dec_ill) begin
        out_vec <= sel_vec;
        out_act <= dec_act;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           sat_flag <= 1'b0;
    else if (accept && !dec_ill && sel_sat) sat_flag <= 1'b1;
    else if (sat_clr)                     sat_flag <= 1'b0;
  end

  // R8: an illegal encoding keeps the previous vector
  a_r8_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_ill |=> out_valid && out_illegal && $stable(out_vec));

  // R8: an illegal encoding never touches the flag apart from a clear
  a_r8_illegal_no_sat: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec_ill && !sat_clr |=> $stable(sat_flag));

  // R5: flag is sticky without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  // R5: a clear with no legal operation empties the flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr && !(accept && !dec_ill) |=> !sat_flag);

  // R9: a stalled result holds
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec) && $stable(out_illegal));

  // R6/R7: nothing above the active width
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && out_act != '0 && out_act < ACT_W'(VW)
      |-> (out_vec >> out_act) == '0);
endmodule

// File: tb/vshl_usat_test.sv
`timescale 1ns/1ps
module vshl_usat_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [127:0] in_vec = '0;
  logic [3:0]   in_immh = '0;
  logic [2:0]   in_immb = '0;
  logic         in_full = 1'b0, in_scalar = 1'b0;
  logic         out_valid, out_ready = 1'b1;
  logic [127:0] out_vec;
  logic         out_illegal, sat_flag;
  logic         sat_clr = 1'b0;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vshl_usat uut (.*);

  localparam int NV = 14;
  localparam logic [127:0] P0 = 128'h7F80_0001_FF10_2030_4050_6070_8090_A0B0;
  localparam logic [127:0] P1 = 128'h0001_0203_0405_0607_0809_0A0B_0C0D_0E0F;
  localparam logic [127:0] P2 = 128'hFFFF_FFFF_0000_0001_7FFF_FFFF_8000_0000;
  localparam logic [127:0] P3 = 128'h0000_0000_0000_0003_8000_0000_0000_0001;
  localparam logic [127:0] P4 = 128'h8080_8080_8080_8080_0102_0304_0506_0708;

  localparam logic [127:0] T_VEC [NV] = '{P0, P1, P0, P1, P2, P2, P3, P3, P0, P3, P4, P1, P1, P1};
  localparam logic [3:0]   T_H   [NV] = '{4'd1, 4'd1, 4'd2, 4'd3, 4'd4, 4'd7, 4'd8, 4'd15, 4'd1, 4'd8, 4'd1, 4'd0, 4'd8, 4'd0};
  localparam logic [2:0]   T_B   [NV] = '{3'd0, 3'd3, 3'd5, 3'd7, 3'd0, 3'd7, 3'd1, 3'd7, 3'd2, 3'd4, 3'd1, 3'd5, 3'd0, 3'd0};
  localparam logic         T_Q   [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic         T_S   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic         T_ILL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  // integer reference model built from the requirements
  function automatic logic [127:0] model(input logic [127:0] v, input logic [3:0] h,
      input logic [2:0] b, input logic q, input logic sc, output logic sat);
    int w, sh, total;
    logic [127:0] r;
    logic signed [135:0] e, maxv;
    logic [63:0] raw;
    r = '0; sat = 1'b0;
    w = h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;          // R1
    sh = int'({h, b}) - w;                               // R2
    total = sc ? w : (q ? 128 : 64);                     // R6 R7
    for (int i = 0; i < total / w; i++) begin
      raw = 64'(v >> (i * w));
      if (w < 64) raw = raw & ((64'd1 << w) - 64'd1);
      e = '0;
      e[63:0] = raw;
      if (raw[w-1]) e = e - (136'sd1 <<< w);             // R3 signed read
      e = e <<< sh;
      maxv = (136'sd1 <<< w) - 136'sd1;
      if (e < 0) begin e = '0; sat = 1'b1; end
      else if (e > maxv) begin e = maxv; sat = 1'b1; end // R4
      r = r | (128'(e[63:0]) << (i * w));
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation, accepted at the next edge, checked at the following negedge
  task automatic issue(input logic [127:0] v, input logic [3:0] h, input logic [2:0] b,
      input logic q, input logic sc, input logic clr);
    @(negedge clk);
    in_vec = v; in_immh = h; in_immb = b; in_full = q; in_scalar = sc;
    in_valid = 1'b1; sat_clr = clr;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
  endtask

  logic [127:0] last_exp, e_vec, e2;
  logic         e_sat, d_sat;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset out_valid", 128'(out_valid), 128'd0);
    chk("R5 reset sat_flag", 128'(sat_flag), 128'd0);
    chk("R9 reset out_vec", out_vec, '0);
    chk("R9 reset in_ready", 128'(in_ready), 128'd1);
    last_exp = '0;

    // table walk; clear pulsed with each op so the flag shows only that op
    for (int k = 0; k < NV; k++) begin
      e_vec = model(T_VEC[k], T_H[k], T_B[k], T_Q[k], T_S[k], e_sat);
      issue(T_VEC[k], T_H[k], T_B[k], T_Q[k], T_S[k], 1'b1);
      chk($sformatf("R8 illegal flag row %0d", k), 128'(out_illegal), 128'(T_ILL[k]));
      chk($sformatf("R9 out_valid row %0d", k), 128'(out_valid), 128'd1);
      if (T_ILL[k]) begin
        chk($sformatf("R8 vector held row %0d", k), out_vec, last_exp);
        chk($sformatf("R8 no sat row %0d", k), 128'(sat_flag), 128'd0);
      end else begin
        chk($sformatf("R1 R2 R3 R4 R6 R7 result row %0d", k), out_vec, e_vec);
        chk($sformatf("R5 R10 sat row %0d", k), 128'(sat_flag), 128'(e_sat));
        last_exp = e_vec;
      end
    end

    // R10: negative upper half inactive under 64-bit width
    e_vec = model(P4, 4'd1, 3'd1, 1'b0, 1'b0, e_sat);
    chk("R10 model expects no sat", 128'(e_sat), 128'd0);
    issue(P4, 4'd1, 3'd1, 1'b0, 1'b0, 1'b1);
    chk("R10 flag stays clear", 128'(sat_flag), 128'd0);
    chk("R6 upper half zero", out_vec[127:64], '0);

    // R5: sticky, clear, and set-over-clear
    issue(P0, 4'd1, 3'd0, 1'b1, 1'b0, 1'b0);
    chk("R5 set by saturation", 128'(sat_flag), 128'd1);
    issue(P1, 4'd1, 3'd0, 1'b0, 1'b0, 1'b0);
    chk("R5 sticky across clean op", 128'(sat_flag), 128'd1);
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    chk("R5 cleared", 128'(sat_flag), 128'd0);
    issue(P0, 4'd1, 3'd0, 1'b1, 1'b0, 1'b1);
    chk("R5 set wins over clear", 128'(sat_flag), 128'd1);
    // R8: illegal op leaves a set flag alone
    issue(P0, 4'd0, 3'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 flag unchanged by illegal", 128'(sat_flag), 128'd1);

    // R9: back-pressure
    @(negedge clk);
    e_vec = model(P1, 4'd2, 3'd1, 1'b1, 1'b0, d_sat);
    e2 = model(P3, 4'd8, 3'd2, 1'b1, 1'b0, d_sat);
    out_ready = 1'b0;
    in_vec = P1; in_immh = 4'd2; in_immb = 3'd1; in_full = 1'b1; in_scalar = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R9 first result", out_vec, e_vec);
    in_vec = P3; in_immh = 4'd8; in_immb = 3'd2;
    chk("R9 ready low while stalled", 128'(in_ready), 128'd0);
    @(negedge clk);
    chk("R9 held under stall", out_vec, e_vec);
    chk("R9 valid under stall", 128'(out_valid), 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result after release", out_vec, e2);
    @(negedge clk);
    chk("R9 drained", 128'(out_valid), 128'd0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule